// File: doc/BRIEF.md
# Interlocked Read Handshake Across Unrelated Clocks

This block carries a single-word read from a requesting agent to a memory target when the two sides run on clocks with no fixed relation. The master side accepts an address, puts it on the address lines, and waits a programmable setup time. It then raises the memory-request and read qualifiers, and one cycle later it raises its own sync strobe. The target sees that strobe through a two-flop synchronizer, looks up the word, and drives it onto the data lines. One target cycle later it raises its acknowledge strobe. The master synchronizes the acknowledge, captures the data, and drops all three of its control lines in the same cycle. The target keeps its acknowledge up until it sees the master strobe low, then drops it and returns the data lines to zero.

The two sides never share timing. Each step is gated only by a handshake line, so the exchange is fully interlocked and works for any clock ratio. A memory target model with a configurable response latency and a decoded window sits inside the block. A read to an address outside that window gets no acknowledge. The master ends such a cycle after a programmable number of cycles and reports an error.

Top module: `hsr_read_top`

## Requirements
- R1: After reset, the bus address, qualifiers, master strobe, acknowledge and data lines are all zero, `rsp_done` is low and `req_ready` is high.
- R2: The address is on the bus and unchanged for at least SETUP_CYC master cycles (default 1) before the memory-request and read qualifiers rise.
- R3: The master strobe rises only after the memory-request and read qualifiers have been high for a full master cycle.
- R4: The target drives the data word at least one target cycle before it raises the acknowledge, and the word holds while the acknowledge is high.
- R5: On completion the master lowers memory-request, read and its strobe in the same cycle as the single-cycle `rsp_done` pulse.
- R6: The target lowers the acknowledge only after its synchronized copy of the master strobe is low. When `rsp_done` pulses on a good read, the acknowledge line is still high.
- R7: When the target lowers the acknowledge, it drives the data lines to zero in the same cycle.
- R8: `req_ready` stays low while the master's synchronized acknowledge is high, so a new cycle never overlaps the tail of the previous one.
- R9: A read to an address below SLV_WORDS (default 16) returns the word (addr * 40503 + 4660) mod 2^DATA_W, with `rsp_err` low.
- R10: A read to an address at or above SLV_WORDS gets no acknowledge. `rsp_done` pulses with `rsp_err` high and `rsp_data` zero exactly SETUP_CYC + 1 + TIMEOUT master cycles after the accepting edge (66 with defaults).
- R11: `rsp_done` is high for exactly one master cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mst_clk | input | 1 | Master-side clock |
| mst_rst_n | input | 1 | Master-side synchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Master idle and previous acknowledge seen low |
| req_addr | input | ADDR_W | Word address to read |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | DATA_W | Captured read word, valid with rsp_done |
| rsp_err | output | 1 | Cycle aborted by timeout, valid with rsp_done |
| slv_clk | input | 1 | Target-side clock |
| slv_rst_n | input | 1 | Target-side synchronous active-low reset |
| bus_addr | output | ADDR_W | Address lines (observation) |
| bus_mreq | output | 1 | Memory-request qualifier (observation) |
| bus_rd | output | 1 | Read qualifier (observation) |
| bus_msyn | output | 1 | Master sync strobe (observation) |
| bus_data | output | DATA_W | Data lines from target (observation) |
| bus_ssyn | output | 1 | Target acknowledge strobe (observation) |

## Verification
The bench uses two clocks with unrelated periods and mixes mapped and unmapped random addresses. This catches a master that grabs data before the acknowledge crosses, which would return stale or zero words. Unmapped reads check that the timeout lands on the exact cycle and clears the data. A counter that is off by one, or a cycle that never aborts, would show up there. At each completion the bench checks that the acknowledge is still high and that `req_ready` is held low. A target that drops too early, or a master that rearms too soon, fails that check. After the target releases, the bench checks that the data lines have gone back to zero.

// File: rtl/hsr_pkg.sv
// Shared state encodings for the interlocked read handshake.
// Assumes: the master and the target each decode their own state type.
package hsr_pkg;

    typedef enum logic [1:0] {
        M_IDLE  = 2'd0,
        M_SETUP = 2'd1,
        M_QUAL  = 2'd2,
        M_WAIT  = 2'd3
    } mst_state_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_LOOK  = 2'd1,
        S_DRIVE = 2'd2,
        S_ACK   = 2'd3
    } slv_state_t;

endpackage

// File: rtl/hsr_sync.sv
// Multi-flop synchronizer for one handshake line that crosses into this clock.
// Assumes: the input is a level that holds until the far side sees it acknowledged.
module hsr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];

    initial assert (STAGES >= 2) else $error("hsr_sync needs at least two stages");
endmodule

// File: rtl/hsr_master.sv
// Bus master sequencer: drives the address, waits for setup, raises the qualifiers,
// then the strobe. It captures data once the synchronized acknowledge arrives, or
// aborts after TIMEOUT cycles.
// Assumes: ssyn_s is already synchronized into mst_clk, and data lines are
// stable whenever the raw acknowledge is high.
module hsr_master
    import hsr_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int SETUP_CYC = 1,
    parameter int TIMEOUT   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_err,
    input  logic              ssyn_s,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              mreq_out,
    output logic              rd_out,
    output logic              msyn_out
);
    localparam int SET_W = $clog2(SETUP_CYC + 1);
    localparam int TMO_W = $clog2(TIMEOUT + 1);

    mst_state_t       state;
    logic [SET_W-1:0] set_cnt;
    logic [TMO_W-1:0] tmo_cnt;

    // Accept only when idle and the previous acknowledge has been seen low.
    assign req_ready = (state == M_IDLE) && !ssyn_s;

    // Main sequencer: address, setup wait, qualifiers, strobe, capture or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= M_IDLE;
            set_cnt  <= '0;
            tmo_cnt  <= '0;
            addr_out <= '0;
            mreq_out <= 1'b0;
            rd_out   <= 1'b0;
            msyn_out <= 1'b0;
            rsp_done <= 1'b0;
            rsp_data <= '0;
            rsp_err  <= 1'b0;
        end else begin
            rsp_done <= 1'b0;
            unique case (state)
                M_IDLE: begin
                    if (req_valid && req_ready) begin
                        addr_out <= req_addr;
                        set_cnt  <= SET_W'(SETUP_CYC);
                        state    <= M_SETUP;
                    end
                end
                M_SETUP: begin
                    if (set_cnt == SET_W'(1)) begin
                        mreq_out <= 1'b1;
                        rd_out   <= 1'b1;
                        state    <= M_QUAL;
                    end else begin
                        set_cnt <= set_cnt - SET_W'(1);
                    end
                end
                M_QUAL: begin
                    msyn_out <= 1'b1;
                    tmo_cnt  <= '0;
                    state    <= M_WAIT;
                end
                M_WAIT: begin
                    if (ssyn_s) begin
                        rsp_data <= data_in;
                        rsp_err  <= 1'b0;
                        rsp_done <= 1'b1;
                        mreq_out <= 1'b0;
                        rd_out   <= 1'b0;
                        msyn_out <= 1'b0;
                        addr_out <= '0;
                        state    <= M_IDLE;
                    end else if (tmo_cnt == TMO_W'(TIMEOUT - 1)) begin
                        rsp_data <= '0;
                        rsp_err  <= 1'b1;
                        rsp_done <= 1'b1;
                        mreq_out <= 1'b0;
                        rd_out   <= 1'b0;
                        msyn_out <= 1'b0;
                        addr_out <= '0;
                        state    <= M_IDLE;
                    end else begin
                        tmo_cnt <= tmo_cnt + TMO_W'(1);
                    end
                end
                default: state <= M_IDLE;
            endcase
        end
    end

    initial assert (SETUP_CYC >= 1) else $error("SETUP_CYC must be at least 1");
    initial assert (TIMEOUT >= 2) else $error("TIMEOUT must be at least 2");

    // R2: the address holds across the edge where the qualifiers rise.
    p_addr_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mreq_out) |-> (addr_out == $past(addr_out)));

    // R3: the strobe follows qualifiers that were already high.
    p_msyn_after_qual_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msyn_out) |-> $past(mreq_out && rd_out));

    // R5: the control lines fall together with the done pulse.
    p_release_together_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(msyn_out) |-> (!mreq_out && !rd_out && rsp_done));

    // R8: a new cycle never starts while the old acknowledge is still seen high.
    p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mreq_out) |-> $past(!ssyn_s, SETUP_CYC));

    // R11: the completion pulse lasts one cycle.
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
endmodule

// File: rtl/hsr_slave.sv
// Memory target model: on a synchronized strobe with both qualifiers high and an
// address inside its window, it waits SLV_LAT cycles, drives the word, then
// acknowledges. It drops the acknowledge and clears the data once the strobe is
// seen low.
// Assumes: address and qualifiers are stable whenever msyn_s is high.
module hsr_slave
    import hsr_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int SLV_WORDS = 16,
    parameter int SLV_LAT   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msyn_s,
    input  logic              mreq_in,
    input  logic              rd_in,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [DATA_W-1:0] data_out,
    output logic              ssyn_out
);
    localparam int IDX_W = $clog2(SLV_WORDS);
    localparam int LAT_W = $clog2(SLV_LAT + 1);

    slv_state_t       state;
    logic [IDX_W-1:0] idx_q;
    logic [LAT_W-1:0] lat_cnt;
    logic [DATA_W-1:0] rom [SLV_WORDS];
    logic             hit;

    // Compute the content of one word from its index.
    function automatic logic [DATA_W-1:0] word_of(input int unsigned a);
        logic [31:0] t;
        t = 32'(a) * 32'd40503 + 32'd4660;
        return t[DATA_W-1:0];
    endfunction

    // Build the read-only content, one word per generated entry.
    for (genvar gi = 0; gi < SLV_WORDS; gi++) begin : g_rom
        assign rom[gi] = word_of(gi);
    end

    // Decode: a request inside the window.
    assign hit = msyn_s && mreq_in && rd_in && (32'(addr_in) < SLV_WORDS);

    // Target sequencer: latch, wait latency, drive word, acknowledge, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            idx_q    <= '0;
            lat_cnt  <= '0;
            data_out <= '0;
            ssyn_out <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (hit) begin
                        idx_q   <= addr_in[IDX_W-1:0];
                        lat_cnt <= LAT_W'(SLV_LAT);
                        state   <= S_LOOK;
                    end
                end
                S_LOOK: begin
                    if (lat_cnt == '0) begin
                        data_out <= rom[idx_q];
                        state    <= S_DRIVE;
                    end else begin
                        lat_cnt <= lat_cnt - LAT_W'(1);
                    end
                end
                S_DRIVE: begin
                    ssyn_out <= 1'b1;
                    state    <= S_ACK;
                end
                S_ACK: begin
                    if (!msyn_s) begin
                        ssyn_out <= 1'b0;
                        data_out <= '0;
                        state    <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    initial assert (SLV_WORDS >= 2 && (1 << IDX_W) == SLV_WORDS)
        else $error("SLV_WORDS must be a power of two");

    // R4: the word is already on the lines when the acknowledge rises.
    p_data_before_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ssyn_out) |-> $stable(data_out));

    // R4: the word holds while the acknowledge stays high.
    p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ssyn_out && $past(ssyn_out)) |-> $stable(data_out));

    // R6: the acknowledge drops only after the strobe was seen low.
    p_ack_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ssyn_out) |-> !$past(msyn_s));

    // R7: the data lines clear together with the acknowledge.
    p_release_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ssyn_out) |-> (data_out == '0));
endmodule

// File: rtl/hsr_read_top.sv
// Top of the interlocked read path: master sequencer, target model, and a
// synchronizer on each handshake line that crosses between the clocks.
// Assumes: mst_clk and slv_clk are unrelated; each reset is synchronous to its clock.
module hsr_read_top #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int SETUP_CYC = 1,
    parameter int TIMEOUT   = 64,
    parameter int SLV_WORDS = 16,
    parameter int SLV_LAT   = 3,
    parameter int SYNC_STG  = 2
) (
    input  logic              mst_clk,
    input  logic              mst_rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_err,
    input  logic              slv_clk,
    input  logic              slv_rst_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_mreq,
    output logic              bus_rd,
    output logic              bus_msyn,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_ssyn
);
    logic ssyn_m;
    logic msyn_t;

    // Acknowledge into the master clock.
    hsr_sync #(.STAGES(SYNC_STG)) u_ssyn_sync (
        .clk(mst_clk), .rst_n(mst_rst_n), .d(bus_ssyn), .q(ssyn_m)
    );

    // Master strobe into the target clock.
    hsr_sync #(.STAGES(SYNC_STG)) u_msyn_sync (
        .clk(slv_clk), .rst_n(slv_rst_n), .d(bus_msyn), .q(msyn_t)
    );

    hsr_master #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETUP_CYC(SETUP_CYC), .TIMEOUT(TIMEOUT)
    ) u_master (
        .clk(mst_clk), .rst_n(mst_rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_done(rsp_done), .rsp_data(rsp_data), .rsp_err(rsp_err),
        .ssyn_s(ssyn_m), .data_in(bus_data),
        .addr_out(bus_addr), .mreq_out(bus_mreq), .rd_out(bus_rd), .msyn_out(bus_msyn)
    );

    hsr_slave #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLV_WORDS(SLV_WORDS), .SLV_LAT(SLV_LAT)
    ) u_slave (
        .clk(slv_clk), .rst_n(slv_rst_n),
        .msyn_s(msyn_t), .mreq_in(bus_mreq), .rd_in(bus_rd), .addr_in(bus_addr),
        .data_out(bus_data), .ssyn_out(bus_ssyn)
    );
endmodule

// File: tb/hsr_read_top_bench.sv
module hsr_read_top_bench;
    localparam int CLK_PERIOD  = 10;
    localparam int SCLK_PERIOD = 14;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int SETUP_CYC = 1;
    localparam int TIMEOUT = 64;
    localparam int SLV_WORDS = 16;
    localparam int TMO_LAT = SETUP_CYC + 1 + TIMEOUT;

    logic mst_clk = 1'b0, slv_clk = 1'b0;
    logic mst_rst_n = 1'b0, slv_rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic req_ready, rsp_done, rsp_err;
    logic [DATA_W-1:0] rsp_data, bus_data;
    logic [ADDR_W-1:0] bus_addr;
    logic bus_mreq, bus_rd, bus_msyn, bus_ssyn;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) mst_clk = ~mst_clk;
    always #(SCLK_PERIOD/2) slv_clk = ~slv_clk;

    hsr_read_top #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETUP_CYC(SETUP_CYC),
        .TIMEOUT(TIMEOUT), .SLV_WORDS(SLV_WORDS)
    ) u_hsr_read_top (
        .mst_clk(mst_clk), .mst_rst_n(mst_rst_n), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .rsp_done(rsp_done),
        .rsp_data(rsp_data), .rsp_err(rsp_err), .slv_clk(slv_clk),
        .slv_rst_n(slv_rst_n), .bus_addr(bus_addr), .bus_mreq(bus_mreq),
        .bus_rd(bus_rd), .bus_msyn(bus_msyn), .bus_data(bus_data), .bus_ssyn(bus_ssyn)
    );

    function automatic logic [DATA_W-1:0] exp_word(input logic [ADDR_W-1:0] a);
        logic [31:0] t;
        t = 32'(a) * 32'd40503 + 32'd4660;
        return t[DATA_W-1:0];
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    // One read: issue, count master edges to done, check everything at done.
    task automatic do_read(input logic [ADDR_W-1:0] a);
        int cycles;
        bit mapped;
        mapped = (32'(a) < SLV_WORDS);
        @(negedge mst_clk);
        req_valid = 1'b1;
        req_addr  = a;
        while (!req_ready) @(negedge mst_clk);
        @(posedge mst_clk);
        #1 req_valid = 1'b0;
        cycles = 0;
        do begin
            @(posedge mst_clk);
            cycles++;
            @(negedge mst_clk);
        end while (!rsp_done && cycles < 400);
        if (mapped) begin
            check(rsp_data == exp_word(a), "R9 data", rsp_data, exp_word(a));
            check(rsp_err == 1'b0, "R9 err", rsp_err, 0);
            check(bus_ssyn == 1'b1, "R6 ack still high at done", bus_ssyn, 1);
            check(req_ready == 1'b0, "R8 ready held low", req_ready, 0);
        end else begin
            check(rsp_err == 1'b1, "R10 err", rsp_err, 1);
            check(rsp_data == '0, "R10 data", rsp_data, 0);
            check(cycles == TMO_LAT, "R10 timeout cycles", cycles, TMO_LAT);
        end
        check(!bus_mreq && !bus_rd && !bus_msyn, "R5 controls low",
              {bus_mreq, bus_rd, bus_msyn}, 0);
        @(negedge mst_clk);
        check(rsp_done == 1'b0, "R11 single pulse", rsp_done, 0);
        cycles = 0;
        while (!req_ready && cycles < 200) begin
            @(negedge mst_clk);
            cycles++;
        end
        check(bus_ssyn == 1'b0 && bus_data == '0, "R7 released to zero",
              {bus_ssyn, bus_data}, 0);
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge mst_clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge slv_clk);
        @(negedge mst_clk);
        mst_rst_n = 1'b1;
        slv_rst_n = 1'b1;
        @(negedge mst_clk);
        check(req_ready == 1'b1 && rsp_done == 1'b0, "R1 ready/done",
              {req_ready, rsp_done}, 2);
        check(bus_addr == '0 && !bus_mreq && !bus_rd && !bus_msyn && !bus_ssyn
              && bus_data == '0, "R1 bus idle",
              {bus_addr, bus_mreq, bus_rd, bus_msyn, bus_ssyn}, 0);
        // Directed corners: first and last mapped word, first unmapped, top address.
        do_read(8'd0);
        do_read(8'(SLV_WORDS - 1));
        do_read(8'(SLV_WORDS));
        do_read(8'hFF);
        do_read(8'd5);
        // Back-to-back random reads, mostly mapped.
        for (int k = 0; k < 30; k++) begin
            logic [ADDR_W-1:0] a;
            a = ($urandom % 8 == 0) ? 8'(SLV_WORDS + $urandom % 200)
                                    : 8'($urandom % SLV_WORDS);
            do_read(a);
        end
        summary();
    end
endmodule